// File: doc/BRIEF.md
# Remote Terminal Message Sequencer

This block is the message layer of a slave terminal on a half-duplex, command/response multi-drop serial bus. It sits behind a word codec. The codec hands it each received 16-bit word together with the sync type and a coding/parity error flag. It takes back the words to send, one pulse per word.

The block recognises command words that carry its strapped terminal address. For a receive command it stores the incoming data words in a per-subaddress buffer bank and then answers with one status word. For a transmit command it answers with a status word and then plays the words of the selected bank back at the codec's word pitch.

The block enforces a fixed response delay. It detects messages that are too short, too long or corrupted, and reports each of these through the message-error flag of its status word. It stays silent for traffic that is meant for other terminals. That includes the terminal-to-terminal case, where another terminal's status and data reach it between its own receive command and its reply.

Top module: `rt_remote_terminal`

## Requirements
- R1: A command word is a word with command sync and no error flag. Its bits are [15:11] terminal address, [10] direction (1 = terminal transmits), [9:5] subaddress, [4:0] word count. It is accepted only when bits [15:11] equal `rt_addr_i`. Any other command, a command flagged with an error, and data words outside a message produce no reply and leave the buffer unchanged.
- R2: A word-count field of 0 stands for 32 data words. Any other value n stands for n words.
- R3: For an accepted receive command, the data words are stored in order in bank `subaddress mod NUM_SA`. The status word is emitted exactly RESP_CYC clock cycles after the edge that captured the last expected data word.
- R4: For an accepted transmit command, the status word follows the command's capture edge by RESP_CYC cycles. The requested words of the selected bank follow in index order, one every WORD_CYC cycles.
- R5: A status word is {terminal address [15:11], message error [10], zeros [9:0]} and is sent with `tx_sync_cmd_o` high. Data words are sent with `tx_sync_cmd_o` low.
- R6: A data word that arrives with `rx_err_i` set is counted but not stored, and the reply carries message error = 1.
- R7: If fewer words than expected arrive and the bus stays quiet for GAP_CYC cycles after the last word, a status word with message error = 1 is emitted GAP_CYC + RESP_CYC cycles after that last word.
- R8: A data word that arrives while the response is pending sets message error and restarts the response delay from that word. For a transmit command, a status word with message error = 1 is sent with no data after it.
- R9: Subaddress 0 or 31 marks a mode command. It is answered by a status word alone, whatever the direction and word count.
- R10: While collecting data, command-sync words not addressed to this terminal are neither counted nor stored. This covers a terminal-to-terminal transfer's transmit command and the other terminal's status word.
- R11: `tx_valid_o` pulses for one cycle per word, and consecutive pulses are at least WORD_CYC cycles apart.
- R12: During and right after reset, no word is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rt_addr_i | input | 5 | Strapped terminal address |
| rx_valid_i | input | 1 | One-cycle pulse: a word was received |
| rx_word_i | input | 16 | Received word |
| rx_sync_cmd_i | input | 1 | Received word had command/status sync (0 = data sync) |
| rx_err_i | input | 1 | Received word had a parity or coding error |
| tx_valid_o | output | 1 | One-cycle pulse: send a word |
| tx_word_o | output | 16 | Word to send |
| tx_sync_cmd_o | output | 1 | Word to send takes command/status sync (0 = data sync) |

## Verification
The bench builds the block with WORD_CYC=4, RESP_CYC=5, GAP_CYC=20 and NUM_SA=4. With these values a full 32-word message, both directions, and a short-message timeout each complete within a few hundred cycles. The bench feeds input words every 4 cycles, one cycle less than the response delay. An extra data word therefore lands inside the pending-response window, where it can be checked against the restarted delay. Using four banks lets three distinct subaddresses hold separate contents at once, so a transfer that writes the wrong bank shows up on the following readback.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int WORD_W    = 16;
  localparam int MAX_WORDS = 32;
  localparam int IDX_W     = $clog2(MAX_WORDS);

  typedef struct packed {
    logic [4:0] addr;
    logic       xmit;
    logic [4:0] sa;
    logic [4:0] wc;
  } cmd_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_WAIT, ST_TX} state_e;
endpackage

// File: rtl/rt_cmd_decode.sv
module rt_cmd_decode #(
  parameter int NUM_SA = 4,
  localparam int SAW = $clog2(NUM_SA)
) (
  input  logic                      rx_valid_i,
  input  logic [rt_pkg::WORD_W-1:0] rx_word_i,
  input  logic                      rx_sync_cmd_i,
  input  logic                      rx_err_i,
  input  logic [4:0]                rt_addr_i,
  output logic                      hit_o,
  output logic                      other_o,
  output logic                      data_o,
  output logic                      xmit_o,
  output logic                      mode_o,
  output logic [SAW-1:0]            bank_o,
  output logic [rt_pkg::IDX_W:0]    cnt_o
);
  rt_pkg::cmd_t c;
  assign c = rx_word_i;

  assign hit_o   = rx_valid_i & rx_sync_cmd_i & ~rx_err_i & (c.addr == rt_addr_i);
  assign other_o = rx_valid_i & rx_sync_cmd_i & ~hit_o;
  assign data_o  = rx_valid_i & ~rx_sync_cmd_i;
  assign xmit_o  = c.xmit;
  assign mode_o  = (c.sa == 5'd0) | (c.sa == 5'd31);
  assign bank_o  = c.sa[SAW-1:0];
  // count field 0 encodes the maximum
  assign cnt_o   = (c.wc == 5'd0) ? (rt_pkg::IDX_W+1)'(rt_pkg::MAX_WORDS)
                                  : {1'b0, c.wc};
endmodule

// File: rtl/rt_word_buffer.sv
module rt_word_buffer #(
  parameter int NUM_SA = 4,
  localparam int SAW = $clog2(NUM_SA)
) (
  input  logic                      clk_i,
  input  logic                      wr_en_i,
  input  logic [SAW-1:0]            wr_bank_i,
  input  logic [rt_pkg::IDX_W-1:0]  wr_idx_i,
  input  logic [rt_pkg::WORD_W-1:0] wr_data_i,
  input  logic [SAW-1:0]            rd_bank_i,
  input  logic [rt_pkg::IDX_W-1:0]  rd_idx_i,
  output logic [rt_pkg::WORD_W-1:0] rd_data_o
);
  logic [rt_pkg::WORD_W-1:0] bank_rd [NUM_SA];

  for (genvar g = 0; g < NUM_SA; g++) begin : g_bank
    logic [rt_pkg::WORD_W-1:0] mem [rt_pkg::MAX_WORDS];
    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_bank_i == SAW'(g)) mem[wr_idx_i] <= wr_data_i;
    end
    assign bank_rd[g] = mem[rd_idx_i];
  end

  assign rd_data_o = bank_rd[rd_bank_i];
endmodule

// File: rtl/rt_seq_ctrl.sv
module rt_seq_ctrl #(
  parameter int WORD_CYC = 1000,
  parameter int RESP_CYC = 300,
  parameter int GAP_CYC  = 2000,
  parameter int NUM_SA   = 4,
  localparam int SAW    = $clog2(NUM_SA),
  localparam int TMAX_A = (GAP_CYC > RESP_CYC) ? GAP_CYC : RESP_CYC,
  localparam int TMAX   = (TMAX_A > WORD_CYC) ? TMAX_A : WORD_CYC,
  localparam int TW     = $clog2(TMAX + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [4:0]                rt_addr_i,
  input  logic                      hit_i,
  input  logic                      other_i,
  input  logic                      data_i,
  input  logic                      xmit_i,
  input  logic                      mode_i,
  input  logic [SAW-1:0]            bank_i,
  input  logic [rt_pkg::IDX_W:0]    cnt_i,
  input  logic                      rx_err_i,
  input  logic [rt_pkg::WORD_W-1:0] rd_data_i,
  output logic                      wr_en_o,
  output logic [SAW-1:0]            wr_bank_o,
  output logic [rt_pkg::IDX_W-1:0]  wr_idx_o,
  output logic [SAW-1:0]            rd_bank_o,
  output logic [rt_pkg::IDX_W-1:0]  rd_idx_o,
  output logic                      tx_valid_o,
  output logic [rt_pkg::WORD_W-1:0] tx_word_o,
  output logic                      tx_sync_cmd_o
);
  import rt_pkg::*;

  localparam logic [TW-1:0] GAP_LAST  = TW'(GAP_CYC - 1);
  localparam logic [TW-1:0] RESP_LAST = TW'(RESP_CYC - 1);
  localparam logic [TW-1:0] WORD_LAST = TW'(WORD_CYC - 1);

  state_e          st_q;
  logic [TW-1:0]   tmr_q;
  logic [IDX_W:0]  need_q, idx_q;
  logic [SAW-1:0]  bank_q;
  logic            xmit_q, err_q;

  assign wr_en_o   = (st_q == ST_RX) & data_i & ~rx_err_i;
  assign wr_bank_o = bank_q;
  assign wr_idx_o  = idx_q[IDX_W-1:0];
  assign rd_bank_o = bank_q;
  assign rd_idx_o  = idx_q[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_IDLE;
      tmr_q         <= '0;
      need_q        <= '0;
      idx_q         <= '0;
      bank_q        <= '0;
      xmit_q        <= 1'b0;
      err_q         <= 1'b0;
      tx_valid_o    <= 1'b0;
      tx_word_o     <= '0;
      tx_sync_cmd_o <= 1'b0;
    end else begin
      tx_valid_o <= 1'b0;
      if (st_q != ST_TX && hit_i) begin
        // own command: starts (or supersedes) a message
        bank_q <= bank_i;
        need_q <= cnt_i;
        idx_q  <= '0;
        tmr_q  <= '0;
        err_q  <= 1'b0;
        xmit_q <= xmit_i & ~mode_i;
        st_q   <= (xmit_i | mode_i) ? ST_WAIT : ST_RX;
      end else begin
        unique case (st_q)
          ST_RX: begin
            if (data_i) begin
              tmr_q <= '0;
              idx_q <= idx_q + 1'b1;
              if (rx_err_i) err_q <= 1'b1;
              if (idx_q + 1'b1 == need_q) st_q <= ST_WAIT;
            end else if (other_i) begin
              tmr_q <= '0;
            end else if (tmr_q == GAP_LAST) begin
              err_q <= 1'b1;
              tmr_q <= '0;
              st_q  <= ST_WAIT;
            end else begin
              tmr_q <= tmr_q + 1'b1;
            end
          end
          ST_WAIT: begin
            if (data_i) begin
              err_q <= 1'b1;
              tmr_q <= '0;
            end else if (tmr_q == RESP_LAST) begin
              tx_valid_o    <= 1'b1;
              tx_word_o     <= {rt_addr_i, err_q, 10'b0};
              tx_sync_cmd_o <= 1'b1;
              tmr_q         <= '0;
              idx_q         <= '0;
              st_q          <= ST_TX;
            end else begin
              tmr_q <= tmr_q + 1'b1;
            end
          end
          ST_TX: begin
            if (tmr_q == WORD_LAST) begin
              tmr_q <= '0;
              if (xmit_q && !err_q && idx_q != need_q) begin
                tx_valid_o    <= 1'b1;
                tx_word_o     <= rd_data_i;
                tx_sync_cmd_o <= 1'b0;
                idx_q         <= idx_q + 1'b1;
              end else begin
                st_q <= ST_IDLE;
              end
            end else begin
              tmr_q <= tmr_q + 1'b1;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rt_remote_terminal.sv
module rt_remote_terminal #(
  parameter int WORD_CYC = 1000,
  parameter int RESP_CYC = 300,
  parameter int GAP_CYC  = 2000,
  parameter int NUM_SA   = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [4:0]  rt_addr_i,
  input  logic        rx_valid_i,
  input  logic [15:0] rx_word_i,
  input  logic        rx_sync_cmd_i,
  input  logic        rx_err_i,
  output logic        tx_valid_o,
  output logic [15:0] tx_word_o,
  output logic        tx_sync_cmd_o
);
  localparam int SAW = $clog2(NUM_SA);
  localparam int IW  = rt_pkg::IDX_W;

  logic           hit, other, data, xmit, mode, wr_en;
  logic [SAW-1:0] bank, wr_bank, rd_bank;
  logic [IW:0]    cnt;
  logic [IW-1:0]  wr_idx, rd_idx;
  logic [15:0]    rd_data;

  rt_cmd_decode #(.NUM_SA(NUM_SA)) u_dec (
    .rx_valid_i(rx_valid_i), .rx_word_i(rx_word_i), .rx_sync_cmd_i(rx_sync_cmd_i),
    .rx_err_i(rx_err_i), .rt_addr_i(rt_addr_i), .hit_o(hit), .other_o(other),
    .data_o(data), .xmit_o(xmit), .mode_o(mode), .bank_o(bank), .cnt_o(cnt)
  );

  rt_word_buffer #(.NUM_SA(NUM_SA)) u_buf (
    .clk_i(clk_i), .wr_en_i(wr_en), .wr_bank_i(wr_bank), .wr_idx_i(wr_idx),
    .wr_data_i(rx_word_i), .rd_bank_i(rd_bank), .rd_idx_i(rd_idx), .rd_data_o(rd_data)
  );

  rt_seq_ctrl #(
    .WORD_CYC(WORD_CYC), .RESP_CYC(RESP_CYC), .GAP_CYC(GAP_CYC), .NUM_SA(NUM_SA)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .rt_addr_i(rt_addr_i), .hit_i(hit),
    .other_i(other), .data_i(data), .xmit_i(xmit), .mode_i(mode), .bank_i(bank),
    .cnt_i(cnt), .rx_err_i(rx_err_i), .rd_data_i(rd_data), .wr_en_o(wr_en),
    .wr_bank_o(wr_bank), .wr_idx_o(wr_idx), .rd_bank_o(rd_bank), .rd_idx_o(rd_idx),
    .tx_valid_o(tx_valid_o), .tx_word_o(tx_word_o), .tx_sync_cmd_o(tx_sync_cmd_o)
  );
endmodule

// File: rtl/rt_remote_terminal_chk.sv
module rt_remote_terminal_chk #(
  parameter int WORD_CYC = 1000
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [4:0]  rt_addr_i,
  input logic        tx_valid_o,
  input logic [15:0] tx_word_o,
  input logic        tx_sync_cmd_o
);
  localparam int GW = $clog2(WORD_CYC + 1);

  logic [GW-1:0] gap_q;
  logic [5:0]    dcnt_q;
  logic          no_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q     <= GW'(WORD_CYC);
      dcnt_q    <= '0;
      no_data_q <= 1'b1;
    end else begin
      if (tx_valid_o) gap_q <= '0;
      else if (gap_q != GW'(WORD_CYC)) gap_q <= gap_q + 1'b1;
      if (tx_valid_o && tx_sync_cmd_o) begin
        dcnt_q    <= '0;
        no_data_q <= tx_word_o[10];
      end else if (tx_valid_o) begin
        dcnt_q <= dcnt_q + 1'b1;
      end
    end
  end

  assert_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |=> !tx_valid_o);

  assert_spacing_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> gap_q >= GW'(WORD_CYC - 1));

  assert_status_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_sync_cmd_o) |-> (tx_word_o[15:11] == rt_addr_i && tx_word_o[9:0] == 10'b0));

  // data only after a clean status
  assert_no_data_after_error_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_sync_cmd_o) |-> !no_data_q);

  assert_max_words_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_sync_cmd_o) |-> dcnt_q < 6'd32);
endmodule

bind rt_remote_terminal rt_remote_terminal_chk #(.WORD_CYC(WORD_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rt_addr_i(rt_addr_i), .tx_valid_o(tx_valid_o),
  .tx_word_o(tx_word_o), .tx_sync_cmd_o(tx_sync_cmd_o)
);

// File: tb/sim_rt_remote_terminal.sv
`timescale 1ns/1ps
module sim_rt_remote_terminal;
  localparam int WD = 4, RS = 5, GP = 20, NSA = 4, SP = 4;
  localparam logic [4:0] ADDR = 5'h0B, OTHER = 5'h05;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_sync = 1'b0, rx_err = 1'b0;
  logic [15:0] rx_word = '0;
  logic tx_valid_o, tx_sync_cmd_o;
  logic [15:0] tx_word_o;

  always #10 clk = ~clk;

  rt_remote_terminal #(.WORD_CYC(WD), .RESP_CYC(RS), .GAP_CYC(GP), .NUM_SA(NSA)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rt_addr_i(ADDR), .rx_valid_i(rx_valid),
    .rx_word_i(rx_word), .rx_sync_cmd_i(rx_sync), .rx_err_i(rx_err),
    .tx_valid_o(tx_valid_o), .tx_word_o(tx_word_o), .tx_sync_cmd_o(tx_sync_cmd_o)
  );

  int total = 0, bad = 0, cyc = 0, last_edge = 0, last_tx = -1, tx_seen = 0;
  bit done = 0;
  int q_cyc[$];
  logic [16:0] q_w[$];
  string q_req[$];
  logic [15:0] mbuf [NSA][32];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] cmd(logic [4:0] a, logic x, logic [4:0] sa, logic [4:0] wc);
    return {a, x, sa, wc};
  endfunction
  function automatic logic [15:0] sts(logic me);
    return {ADDR, me, 10'b0};
  endfunction

  task automatic push(input int c, input logic [15:0] w, input logic s, input string r);
    q_cyc.push_back(c); q_w.push_back({s, w}); q_req.push_back(r);
  endtask

  task automatic send(input logic [15:0] w, input logic c, input logic e);
    @(negedge clk);
    rx_valid = 1'b1; rx_word = w; rx_sync = c; rx_err = e; last_edge = cyc + 1;
    @(negedge clk);
    rx_valid = 1'b0; rx_sync = 1'b0; rx_err = 1'b0;
    repeat (SP - 2) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (q_cyc.size() > 0) @(negedge clk);
    repeat (2 * WD + 4) @(negedge clk);
  endtask

  // receive message: nsend data words, optional bad word and extra word
  task automatic do_receive(input int sa, input int wc, input int nsend, input int bad_idx,
                            input bit extra, input string r);
    int n;
    logic [15:0] d;
    n = (wc == 0) ? 32 : wc;
    send(cmd(ADDR, 1'b0, 5'(sa), 5'(wc)), 1'b1, 1'b0);
    for (int i = 0; i < nsend; i++) begin
      d = 16'(sa * 16'h0400 + i * 16'h0013 + 16'h5A00 + wc);
      send(d, 1'b0, 1'(i == bad_idx));
      if (i != bad_idx) mbuf[sa % NSA][i] = d;
    end
    if (extra) begin
      send(16'hBEEF, 1'b0, 1'b0);
      push(last_edge + RS, sts(1'b1), 1'b1, r);
    end else if (nsend >= n) push(last_edge + RS, sts(1'(bad_idx >= 0)), 1'b1, r);
    else push(last_edge + GP + RS, sts(1'b1), 1'b1, r);
    wait_idle();
  endtask

  task automatic do_transmit(input int sa, input int wc, input string r);
    int n, c;
    n = (wc == 0) ? 32 : wc;
    send(cmd(ADDR, 1'b1, 5'(sa), 5'(wc)), 1'b1, 1'b0);
    c = last_edge + RS;
    push(c, sts(1'b0), 1'b1, r);
    for (int k = 0; k < n; k++) push(c + (k + 1) * WD, mbuf[sa % NSA][k], 1'b0, r);
    wait_idle();
  endtask

  task automatic check_silent(input int n0, input string r);
    repeat (RS + GP + 3 * WD) @(negedge clk);
    total++;
    if (tx_seen != n0) begin
      bad++;
      $display("FAIL %s reply count actual=%0d expected=%0d", r, tx_seen - n0, 0);
    end
  endtask

  // per-clock comparison against expected word schedule
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (tx_valid_o) begin
        tx_seen++;
        if (last_tx >= 0) begin
          total++;
          if (cyc - last_tx < WD) begin
            bad++;
            $display("FAIL R11 word spacing actual=%0d expected>=%0d", cyc - last_tx, WD);
          end
        end
        last_tx = cyc;
        total++;
        if (q_cyc.size() == 0) begin
          bad++;
          $display("FAIL R1 unexpected word actual=%b/%h@%0d expected=none",
                   tx_sync_cmd_o, tx_word_o, cyc);
        end else begin
          if (q_cyc[0] != cyc || q_w[0] !== {tx_sync_cmd_o, tx_word_o}) begin
            bad++;
            $display("FAIL %s actual=%b/%h@%0d expected=%b/%h@%0d", q_req[0],
                     tx_sync_cmd_o, tx_word_o, cyc, q_w[0][16], q_w[0][15:0], q_cyc[0]);
          end
          void'(q_cyc.pop_front()); void'(q_w.pop_front()); void'(q_req.pop_front());
        end
      end else if (q_cyc.size() > 0 && q_cyc[0] < cyc) begin
        total++; bad++;
        $display("FAIL %s missing word actual=none expected=%b/%h@%0d", q_req[0],
                 q_w[0][16], q_w[0][15:0], q_cyc[0]);
        void'(q_cyc.pop_front()); void'(q_w.pop_front()); void'(q_req.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    total++;
    if (tx_valid_o !== 1'b0) begin
      bad++; $display("FAIL R12 in reset actual=%b expected=0", tx_valid_o);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    total++;
    if (tx_valid_o !== 1'b0) begin
      bad++; $display("FAIL R12 after reset actual=%b expected=0", tx_valid_o);
    end

    do_receive(1, 3, 3, -1, 1'b0, "R5 status after receive");
    do_receive(1, 3, 3, -1, 1'b0, "R3 receive status timing");
    do_transmit(1, 3, "R4 transmit of stored words");
    do_receive(2, 0, 32, -1, 1'b0, "R2 count zero receive");
    do_transmit(2, 0, "R2 count zero transmit");

    // R1: foreign address and flagged command ignored, buffer untouched
    n0 = tx_seen;
    send(cmd(OTHER, 1'b0, 5'd1, 5'd2), 1'b1, 1'b0);
    send(16'h1111, 1'b0, 1'b0);
    send(16'h2222, 1'b0, 1'b0);
    send(cmd(ADDR, 1'b1, 5'd1, 5'd2), 1'b1, 1'b1);
    check_silent(n0, "R1 ignored commands");
    do_transmit(1, 3, "R1 buffer unchanged");

    do_receive(3, 4, 4, 2, 1'b0, "R6 coding error on data");
    do_receive(3, 4, 2, -1, 1'b0, "R7 short message timeout");
    do_receive(3, 2, 2, -1, 1'b1, "R8 extra word on receive");

    // R8: data word after transmit command
    send(cmd(ADDR, 1'b1, 5'd1, 5'd3), 1'b1, 1'b0);
    send(16'h0F0F, 1'b0, 1'b0);
    push(last_edge + RS, sts(1'b1), 1'b1, "R8 transmit without data");
    wait_idle();

    // R9: mode commands in both directions
    send(cmd(ADDR, 1'b1, 5'd0, 5'd5), 1'b1, 1'b0);
    push(last_edge + RS, sts(1'b0), 1'b1, "R9 mode transmit");
    wait_idle();
    send(cmd(ADDR, 1'b0, 5'd31, 5'd3), 1'b1, 1'b0);
    push(last_edge + RS, sts(1'b0), 1'b1, "R9 mode receive");
    wait_idle();

    // R10: terminal-to-terminal, this terminal receives
    send(cmd(ADDR, 1'b0, 5'd3, 5'd2), 1'b1, 1'b0);
    send(cmd(OTHER, 1'b1, 5'd7, 5'd2), 1'b1, 1'b0);
    send({OTHER, 11'b0}, 1'b1, 1'b0);
    send(16'hA5A5, 1'b0, 1'b0); mbuf[3][0] = 16'hA5A5;
    send(16'h5A5A, 1'b0, 1'b0); mbuf[3][1] = 16'h5A5A;
    push(last_edge + RS, sts(1'b0), 1'b1, "R10 terminal-to-terminal status");
    wait_idle();
    do_transmit(3, 2, "R10 terminal-to-terminal data");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule